// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block produces a single output pulse of programmable length each time it is triggered. A down-counter is loaded from a reload register when a trigger is accepted, and the output stays high while the counter steps down on count-source tick pulses supplied from outside. When the count runs out the output returns low, an interrupt request flag is raised, and the counter is reloaded so that the next trigger starts a fresh pulse without software help.

Software configures the block through a simple write port: a start bit, a mode field, a trigger-source select (a write-only software trigger or a rising edge on an asynchronous pin), the reload value, the interrupt flag and a cutoff enable. A trigger that lands while a pulse is running stretches the pulse. Clearing the start bit aborts a pulse at once. A separate active-low cutoff input can force the output driver off without waiting for any clock.

Top module: `oneshot_timer`

## Requirements
- R1: After reset the start bit is 0, the output is low and driven, and the interrupt flag is 0; software triggers and ticks cause no pulse until the start bit (address 0, bit 0) is set and the mode field holds one-shot.
- R2: Writes to the mode field (address 1, bits 1:0; 0 = timer, 1 = event counter, 2 = one-shot) and to the trigger-source bit (address 2, bit 0; 0 = software, 1 = external pin) are ignored while the start bit is 1.
- R3: Writing 0 to the start bit while it is 1 drives the output low on that clock edge, reloads the counter so the next pulse has full length, and sets the interrupt flag one clock later.
- R4: Writing one-shot to the mode field while it held timer or event-counter mode sets the interrupt flag; rewriting one-shot when already selected does not; writing 0 to bit 0 of address 5 clears the flag.
- R5: A software trigger (bit 0 written 1 at address 4, software source selected) is taken at the next tick; the output rises on that tick and stays high for exactly the reload value (address 3) in ticks, changing only on ticks.
- R6: With the external source selected, a rising edge on the trigger pin, after two-flop synchronisation, is taken at the next tick; software triggers are then ignored.
- R7: When the count ends the output goes low and the interrupt flag is set, with the start bit still 1, and a later trigger starts a new full pulse.
- R8: A trigger with a reload value of 0 produces no pulse and no interrupt.
- R9: A trigger accepted during a pulse lets one more decrement happen on that tick, then reloads the counter on the following tick; the output stays high and falls reload ticks after the reloading tick.
- R10: A trigger that is pending at the tick directly after the tick that accepted the previous trigger is discarded.
- R11: While the cutoff enable (address 6, bit 0) is 1, a low level on the cutoff input releases the output driver immediately, without a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-source enable, one clock wide per period |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | W | Register write data |
| trig_pin_i | input | 1 | Asynchronous external trigger pin |
| cutoff_ni | input | 1 | Asynchronous active-low output cutoff request |
| pulse_o | output | 1 | Pulse output level |
| pulse_oe_o | output | 1 | Output driver enable; 0 means high impedance |
| irq_o | output | 1 | Interrupt request flag |

## Verification
Register writes take effect on the clock edge inside the write, so the output drop on stop and the mode-select flag are read half a cycle after that edge, while the stop interrupt is due one whole clock later and is read both before and after to pin the delay. Pulse results are due on ticks only: every tick is one isolated clock-wide pulse followed by a sample at the next falling edge, and pulse length is counted as the number of such samples that see the output high. External triggers are given several clocks to cross the synchroniser before the tick that should take them, and the cutoff is sampled a nanosecond after its input moves, with no clock in between.

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          trig_pin_i,
  input  logic          cutoff_ni,
  output logic          pulse_o,
  output logic          pulse_oe_o,
  output logic          irq_o
);

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_SRC  = AW'(2);
  localparam logic [AW-1:0] A_RLD  = AW'(3);
  localparam logic [AW-1:0] A_TRIG = AW'(4);
  localparam logic [AW-1:0] A_IRQ  = AW'(5);
  localparam logic [AW-1:0] A_CUT  = AW'(6);
  localparam logic [1:0]    M_ONESHOT = 2'd2;
  localparam logic [W-1:0]  ONE = W'(1);

  logic         start_q, ext_sel_q, cut_en_q;
  logic [1:0]   mode_q;
  logic [W-1:0] reload_q, cnt_q;
  logic         active_q, pend_q, fresh_q, rearm_q, stop_q, irq_q;
  logic [2:0]   sync_q;

  logic running, cfg_ok, sw_trig, ext_trig, trig_in, stop_now, mode_irq;
  logic step, accept, expire;

  assign running  = start_q && (mode_q == M_ONESHOT);
  assign cfg_ok   = wr_en_i && !start_q;
  assign sw_trig  = wr_en_i && wr_addr_i == A_TRIG && wr_data_i[0] && running && !ext_sel_q;
  assign ext_trig = sync_q[1] && !sync_q[2] && running && ext_sel_q;
  assign trig_in  = sw_trig || ext_trig;
  assign stop_now = wr_en_i && wr_addr_i == A_CTRL && !wr_data_i[0] && start_q;
  assign mode_irq = cfg_ok && wr_addr_i == A_MODE && wr_data_i[1:0] == M_ONESHOT
                    && mode_q != M_ONESHOT;
  assign step     = tick_i && running && !stop_now;
  assign accept   = pend_q && !fresh_q;
  assign expire   = step && active_q && !rearm_q && !accept && cnt_q <= ONE;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], trig_pin_i};
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      start_q   <= 1'b0;
      mode_q    <= '0;
      ext_sel_q <= 1'b0;
      cut_en_q  <= 1'b0;
      reload_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_CTRL: start_q <= wr_data_i[0];
        A_MODE: if (cfg_ok) mode_q <= wr_data_i[1:0];
        A_SRC:  if (cfg_ok) ext_sel_q <= wr_data_i[0];
        A_RLD:  reload_q <= wr_data_i;
        A_CUT:  cut_en_q <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      fresh_q  <= 1'b0;
      rearm_q  <= 1'b0;
    end else if (stop_now) begin
      cnt_q    <= reload_q;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      fresh_q  <= 1'b0;
      rearm_q  <= 1'b0;
    end else if (step) begin
      pend_q  <= trig_in;
      fresh_q <= 1'b0;
      if (active_q) begin
        if (rearm_q) begin
          cnt_q   <= reload_q;
          rearm_q <= 1'b0;
        end else if (accept) begin
          rearm_q <= 1'b0 | 1'b1;
          fresh_q <= 1'b1;
          cnt_q   <= cnt_q - W'(cnt_q != '0);
        end else if (cnt_q <= ONE) begin
          active_q <= 1'b0;
          cnt_q    <= reload_q;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end else if (accept && reload_q != '0) begin
        active_q <= 1'b1;
        cnt_q    <= reload_q;
        fresh_q  <= 1'b1;
      end
    end else if (trig_in) begin
      pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stop_q <= stop_now;
      if (stop_q || expire || mode_irq)
        irq_q <= 1'b1;
      else if (wr_en_i && wr_addr_i == A_IRQ && !wr_data_i[0])
        irq_q <= 1'b0;
    end
  end

  assign pulse_o    = active_q;
  assign pulse_oe_o = !(cut_en_q && !cutoff_ni);
  assign irq_o      = irq_q;

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |-> !pulse_o);

  p_cfg_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && wr_en_i && (wr_addr_i == A_MODE || wr_addr_i == A_SRC))
    |=> ($stable(mode_q) && $stable(ext_sel_q)));

  p_stop_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |=> irq_o);

  p_tick_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !(wr_en_i && wr_addr_i == A_CTRL)) |=> $stable(pulse_o));

  p_end_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pulse_o) && start_q) |-> irq_o);

  p_zero_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && start_q && !pulse_o && reload_q == '0) |=> !pulse_o);

endmodule

// File: tb/test_oneshot_timer.sv
module test_oneshot_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig_pin = 1'b0;
  logic        cutoff_n = 1'b1;
  logic        pulse, pulse_oe, irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  oneshot_timer i_oneshot_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .trig_pin_i(trig_pin),
    .cutoff_ni(cutoff_n), .pulse_o(pulse), .pulse_oe_o(pulse_oe), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic run_pulse(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      tk();
      if (pulse) hi++;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out", pulse, 0);
    chk("R1 oe", pulse_oe, 1);
    chk("R1 irq", irq, 0);
    wr(3, 4);
    wr(4, 1);
    run_pulse(3, hi);
    chk("R1 no pulse while stopped", hi, 0);

    wr(1, 2);
    chk("R4 reset->oneshot", irq, 1);
    wr(5, 0);
    chk("R4 clear", irq, 0);
    wr(1, 0); wr(1, 2);
    chk("R4 timer->oneshot", irq, 1);
    wr(5, 0);
    wr(1, 1); wr(1, 2);
    chk("R4 event->oneshot", irq, 1);
    wr(5, 0);
    wr(1, 2);
    chk("R4 reselect no irq", irq, 0);

    wr(0, 1);
    for (int r = 0; r < 8; r++) begin
      wr(3, 16'(r));
      wr(5, 0);
      wr(4, 1);
      run_pulse(r + 3, hi);
      chk($sformatf("R5 width reload=%0d", r), hi, r);
      chk($sformatf("R7 irq reload=%0d", r), irq, r > 0 ? 1 : 0);
      if (r == 0) chk("R8 no irq", irq, 0);
      chk("R7 start kept low out", pulse, 0);
    end

    wr(1, 0);
    wr(2, 1);
    wr(3, 3);
    wr(5, 0);
    wr(4, 1);
    run_pulse(6, hi);
    chk("R2 writes ignored, sw pulse", hi, 3);

    wr(3, 4);
    wr(5, 0);
    wr(4, 1);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      tk();
      if (pulse) hi++;
      if (i == 1) wr(4, 1);
    end
    chk("R9 retrigger width", hi, 7);
    chk("R9 irq", irq, 1);

    wr(3, 3);
    wr(4, 1);
    hi = 0;
    for (int i = 0; i < 8; i++) begin
      tk();
      if (pulse) hi++;
      if (i == 0) wr(4, 1);
    end
    chk("R10 early trigger dropped", hi, 3);

    wr(3, 5);
    wr(5, 0);
    wr(4, 1);
    tk(); tk();
    chk("R3 running", pulse, 1);
    wr(0, 0);
    chk("R3 out low at stop", pulse, 0);
    chk("R3 irq not yet", irq, 0);
    @(negedge clk);
    chk("R3 irq one clock later", irq, 1);
    wr(5, 0);
    wr(0, 1);
    wr(4, 1);
    run_pulse(8, hi);
    chk("R3 full width after stop", hi, 5);

    wr(0, 0);
    wr(2, 1);
    wr(0, 1);
    wr(5, 0);
    @(negedge clk);
    trig_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 no change without tick", pulse, 0);
    tk();
    chk("R6 ext edge taken", pulse, 1);
    trig_pin = 1'b0;
    run_pulse(6, hi);
    chk("R6 ext width rest", hi, 4);
    wr(4, 1);
    run_pulse(3, hi);
    chk("R6 sw ignored on ext", hi, 0);

    cutoff_n = 1'b0; #1;
    chk("R11 disabled", pulse_oe, 1);
    wr(6, 1); #1;
    chk("R11 cut", pulse_oe, 0);
    cutoff_n = 1'b1; #1;
    chk("R11 released", pulse_oe, 1);
    cutoff_n = 1'b0; #1;
    chk("R11 async cut", pulse_oe, 0);
    wr(6, 0); #1;
    chk("R11 enable off", pulse_oe, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule